// File: doc/BRIEF.md
# Mode-Gated Watchdog Timer

This block is a watchdog that counts prescaled ticks in an 8-bit counter. If the counter rolls past its top value before software clears it, the block raises a reset request for one clock cycle. A clear strobe stands for the clear-watchdog instruction and sets the counter back to zero. The block also keeps a sticky timeout flag, so that software can find out after the restart that the last reset came from the watchdog.

A two-bit mode code controls whether the watchdog runs. The code is sampled once, when the block leaves reset, and is then held. It selects one of four behaviours:
- never run;
- always run;
- run only while the core is awake;
- follow a run-time software enable bit.

While the watchdog is stopped, its counter is held at zero, so each restart begins a full timeout period. There are two reset inputs. The system reset, which the request itself is meant to drive, restarts the counter and the mode capture. The power-on reset is the only reset that clears the timeout flag.

Top module: `wdt_mode_gated`

## Requirements
- R1: While running, the counter advances by one on each clock edge where `tick_i` is high and holds otherwise. A tick taken with the counter at 255 wraps it to 0. That wrap drives `wdt_rst_o` high for exactly one cycle, the cycle after the wrapping edge. From zero with ticks every cycle, the request follows the 256th tick edge.
- R2: Mode code 2'b11 runs the watchdog at all times, whatever `sleep_i` and `sw_en_i` are.
- R3: Mode code 2'b00 never runs the watchdog: no request is raised, with any tick, sleep or enable pattern.
- R4: Mode code 2'b10 runs the watchdog while `sleep_i` is low and stops it while `sleep_i` is high.
- R5: Mode code 2'b01 runs the watchdog exactly while `sw_en_i` is high.
- R6: `cfg_mode_i` is sampled on the first clock edge after `rst_ni` is released, and the watchdog is stopped until that edge. Later changes of `cfg_mode_i` have no effect until the next `rst_ni`.
- R7: A high `clr_i` sets the counter to zero on the next edge. If that edge would wrap the counter, the clear wins and no request is raised.
- R8: While the watchdog is stopped, the counter is held at zero. Running again with ticks every cycle gives a request after 256 tick edges.
- R9: `timeout_o` rises together with each request. It stays high through `rst_ni` and is cleared by `sts_clr_i` or by `por_ni`. A request on the same edge as `sts_clr_i` leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Power-on reset, asynchronous, active low; clears the timeout flag |
| rst_ni | input | 1 | System reset, asynchronous, active low; restarts counter and mode capture |
| cfg_mode_i | input | 2 | Mode code, sampled once after reset: 00 off, 01 software, 10 awake only, 11 on |
| tick_i | input | 1 | Prescaled count enable |
| clr_i | input | 1 | Watchdog clear strobe |
| sleep_i | input | 1 | High while the core sleeps |
| sw_en_i | input | 1 | Run-time software enable used in mode 01 |
| sts_clr_i | input | 1 | Software clear of the timeout flag |
| wdt_rst_o | output | 1 | One-cycle watchdog reset request |
| timeout_o | output | 1 | Sticky timeout status flag |

## Verification
The bench runs each of the four mode codes through reset. For each mode it drives `sleep_i` and `sw_en_i` both ways, so that the bench can tell a mode that ignores a gate from one that obeys it. The exact cycle of each request is predicted from the tick count. This separates three cases:
- a counter that restarts from zero after a stop;
- a counter that resumes where it stopped;
- a clear that loses to a wrap on the same edge.

Changing `cfg_mode_i` after capture, holding ticks low, and pulsing `rst_ni` between requests show whether the mode is frozen, whether the count is gated by ticks, and whether the flag is sticky.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    WM_OFF   = 2'b00,
    WM_SW    = 2'b01,
    WM_AWAKE = 2'b10,
    WM_ON    = 2'b11
  } wdt_mode_e;
endpackage

// File: rtl/wdt_mode_latch.sv
// Samples the mode code once on the first edge after reset release.
module wdt_mode_latch
  import wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] cfg_mode_i,
  output wdt_mode_e  mode_o,
  output logic       cap_o
);
  wdt_mode_e mode_q, mode_d;
  logic      cap_q, cap_d;
  logic      cap_en;

  assign cap_en = ~cap_q;

  always_comb begin
    mode_d = mode_q;
    cap_d  = cap_q;
    if (cap_en) begin
      mode_d = wdt_mode_e'(cfg_mode_i);
      cap_d  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= WM_OFF;
      cap_q  <= 1'b0;
    end else if (cap_en) begin
      mode_q <= mode_d;
      cap_q  <= cap_d;
    end
  end

  assign mode_o = mode_q;
  assign cap_o  = cap_q;
endmodule

// File: rtl/wdt_run_decode.sv
// Turns the frozen mode code and the live gates into a run qualifier.
module wdt_run_decode
  import wdt_pkg::*;
(
  input  wdt_mode_e mode_i,
  input  logic      sleep_i,
  input  logic      sw_en_i,
  output logic      run_o
);
  always_comb begin
    unique case (mode_i)
      WM_OFF:   run_o = 1'b0;
      WM_SW:    run_o = sw_en_i;
      WM_AWAKE: run_o = ~sleep_i;
      WM_ON:    run_o = 1'b1;
      default:  run_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/wdt_counter.sv
// Tick counter with clear priority, zero hold when stopped, registered request.
module wdt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             clr_i,
  output logic             wrap_o,
  output logic             req_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap_d;
  logic             req_q;

  always_comb begin
    cnt_d  = cnt_q;
    wrap_d = 1'b0;
    if (!run_i || clr_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d  = cnt_q + CNT_ONE;
      wrap_d = (cnt_q == CNT_MAX);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= wrap_d;
    end
  end

  assign wrap_o = wrap_d;
  assign req_o  = req_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/wdt_flag.sv
// Sticky timeout flag in the power-on reset domain; set beats clear.
module wdt_flag (
  input  logic clk_i,
  input  logic por_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d, flag_en;

  assign flag_en = set_i | clr_i;

  always_comb begin
    flag_d = flag_q;
    if (set_i)      flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)      flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/wdt_mode_gated.sv
module wdt_mode_gated #(
  parameter int CNT_W = 8
) (
  input  logic       clk_i,
  input  logic       por_ni,
  input  logic       rst_ni,
  input  logic [1:0] cfg_mode_i,
  input  logic       tick_i,
  input  logic       clr_i,
  input  logic       sleep_i,
  input  logic       sw_en_i,
  input  logic       sts_clr_i,
  output logic       wdt_rst_o,
  output logic       timeout_o
);
  import wdt_pkg::*;

  wdt_mode_e        mode_q;
  logic             cap_q;
  logic             run;
  logic             wrap;
  logic [CNT_W-1:0] cnt_q;

  wdt_mode_latch u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_mode_i (cfg_mode_i),
    .mode_o     (mode_q),
    .cap_o      (cap_q)
  );

  wdt_run_decode u_dec (
    .mode_i  (mode_q),
    .sleep_i (sleep_i),
    .sw_en_i (sw_en_i),
    .run_o   (run)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_i (tick_i),
    .clr_i  (clr_i),
    .wrap_o (wrap),
    .req_o  (wdt_rst_o),
    .cnt_o  (cnt_q)
  );

  wdt_flag u_flag (
    .clk_i  (clk_i),
    .por_ni (por_ni),
    .set_i  (wrap),
    .clr_i  (sts_clr_i),
    .flag_o (timeout_o)
  );
endmodule

// File: rtl/wdt_mode_gated_chk.sv
module wdt_mode_gated_chk
  import wdt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             por_ni,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             sleep_i,
  input logic             sts_clr_i,
  input logic             wdt_rst_o,
  input logic             timeout_o,
  input wdt_mode_e        mode_q,
  input logic             cap_q,
  input logic             run,
  input logic [CNT_W-1:0] cnt_q
);
  p_req_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o);

  p_off_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_q && mode_q == WM_OFF) |=> (cnt_q == '0 && !wdt_rst_o));

  p_sleep_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_q && mode_q == WM_AWAKE && sleep_i) |=> (cnt_q == '0));

  p_mode_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_q |=> (cap_q && $stable(mode_q)));

  p_clear_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!wdt_rst_o && cnt_q == '0));

  p_stop_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> (cnt_q == '0));

  p_flag_with_req_r9: assert property (@(posedge clk_i) disable iff (!por_ni)
    wdt_rst_o |-> timeout_o);

  p_flag_sticky_r9: assert property (@(posedge clk_i) disable iff (!por_ni)
    (timeout_o && !sts_clr_i) |=> timeout_o);
endmodule

bind wdt_mode_gated wdt_mode_gated_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .por_ni    (por_ni),
  .rst_ni    (rst_ni),
  .clr_i     (clr_i),
  .sleep_i   (sleep_i),
  .sts_clr_i (sts_clr_i),
  .wdt_rst_o (wdt_rst_o),
  .timeout_o (timeout_o),
  .mode_q    (mode_q),
  .cap_q     (cap_q),
  .run       (run),
  .cnt_q     (cnt_q)
);

// File: tb/tb_wdt_mode_gated.sv
module tb_wdt_mode_gated;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 150000;

  logic       clk = 1'b0;
  logic       por_n, rst_n;
  logic [1:0] cfg_mode;
  logic       tick, clr, sleep, sw_en, sts_clr;
  logic       wdt_rst, timeout;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int bark_cnt = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_mode_gated dut (
    .clk_i      (clk),
    .por_ni     (por_n),
    .rst_ni     (rst_n),
    .cfg_mode_i (cfg_mode),
    .tick_i     (tick),
    .clr_i      (clr),
    .sleep_i    (sleep),
    .sw_en_i    (sw_en),
    .sts_clr_i  (sts_clr),
    .wdt_rst_o  (wdt_rst),
    .timeout_o  (timeout)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: every request is compared to the next predicted cycle.
  always @(negedge clk) begin
    if (wdt_rst === 1'b1) begin
      bark_cnt++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1 unexpected request at cycle", cyc, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(cyc == e, "R1 request cycle", cyc, e);
      end
    end
  end

  task automatic do_reset(input logic [1:0] m, input bit por, output int r);
    @(negedge clk);
    cfg_mode = m;
    rst_n = 1'b0;
    if (por) por_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    por_n = 1'b1;
    r = cyc;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic drain(input string tag);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  initial begin
    int r, u, b0, b1, t, bc;
    por_n = 1'b0; rst_n = 1'b0; cfg_mode = 2'b00;
    tick = 1'b1; clr = 1'b0; sleep = 1'b0; sw_en = 1'b0; sts_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk(wdt_rst == 1'b0, "reset state request", int'(wdt_rst), 0);
    chk(timeout == 1'b0, "reset state flag", int'(timeout), 0);

    // R2 / R1: always-on mode ignores sleep and software enable
    sleep = 1'b1; sw_en = 1'b0;
    do_reset(2'b11, 1'b1, r);
    exp_q.push_back(r + 257);
    exp_q.push_back(r + 513);
    wait_until(r + 514);
    drain("R2 always-on requests");
    chk(timeout == 1'b1, "R9 flag after request", int'(timeout), 1);

    // R9: flag survives system reset; R3 / R6: off mode, later code ignored
    sleep = 1'b0; sw_en = 1'b1;
    do_reset(2'b00, 1'b0, r);
    chk(timeout == 1'b1, "R9 flag kept through rst", int'(timeout), 1);
    @(negedge clk);
    cfg_mode = 2'b11;
    bc = bark_cnt;
    repeat (600) @(negedge clk);
    chk(bark_cnt == bc, "R3 R6 off mode stays quiet", bark_cnt - bc, 0);
    sts_clr = 1'b1;
    @(negedge clk);
    sts_clr = 1'b0;
    chk(timeout == 1'b0, "R9 software clear", int'(timeout), 0);

    // R1: no ticks, no advance
    tick = 1'b0;
    do_reset(2'b11, 1'b0, r);
    bc = bark_cnt;
    repeat (400) @(negedge clk);
    chk(bark_cnt == bc, "R1 no tick no request", bark_cnt - bc, 0);
    tick = 1'b1;
    u = cyc;
    exp_q.push_back(u + 256);
    wait_until(u + 257);
    drain("R1 tick resumes full period");

    // R4: awake-only mode
    sleep = 1'b1; sw_en = 1'b1;
    do_reset(2'b10, 1'b0, r);
    bc = bark_cnt;
    repeat (400) @(negedge clk);
    chk(bark_cnt == bc, "R4 asleep stays quiet", bark_cnt - bc, 0);
    sleep = 1'b0;
    u = cyc;
    exp_q.push_back(u + 256);
    wait_until(u + 257);
    drain("R4 awake request");

    // R5 / R8: software-enable mode, stop mid-count, restart from zero
    sleep = 1'b1; sw_en = 1'b1;
    do_reset(2'b01, 1'b0, r);
    repeat (150) @(negedge clk);
    sw_en = 1'b0;
    bc = bark_cnt;
    repeat (300) @(negedge clk);
    chk(bark_cnt == bc, "R5 disabled stays quiet", bark_cnt - bc, 0);
    sw_en = 1'b1;
    u = cyc;
    exp_q.push_back(u + 256);
    wait_until(u + 257);
    drain("R8 full period after restart");

    // R7: clear restarts the period and beats a wrap on the same edge
    sleep = 1'b0;
    do_reset(2'b11, 1'b0, r);
    repeat (100) @(negedge clk);
    t = cyc;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    b0 = t + 257;
    exp_q.push_back(b0);
    wait_until(b0 - 5);
    sts_clr = 1'b1;
    wait_until(b0 - 1);
    chk(timeout == 1'b0, "R9 flag cleared before request", int'(timeout), 0);
    @(negedge clk);
    chk(timeout == 1'b1, "R9 set wins over clear", int'(timeout), 1);
    sts_clr = 1'b0;
    b1 = b0 + 256;
    wait_until(b1 - 1);
    clr = 1'b1;
    bc = bark_cnt;
    @(negedge clk);
    clr = 1'b0;
    chk(bark_cnt == bc, "R7 clear beats wrap", bark_cnt - bc, 0);
    exp_q.push_back(b1 + 256);
    wait_until(b1 + 257);
    drain("R7 period after clear");

    // R9: power-on reset clears the flag
    chk(timeout == 1'b1, "R9 flag set before por", int'(timeout), 1);
    do_reset(2'b00, 1'b1, r);
    chk(timeout == 1'b0, "R9 por clears flag", int'(timeout), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", cyc, WATCHDOG_CYC);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule